// File: doc/BRIEF.md
# Labeled Access Ordering Gate

This block sits between one processor's memory request stream and the memory system. Every access carries a label that marks it as ordinary, acquire or release. The gate releases an access to memory only when the relaxed ordering model selected by a mode input allows it. That decision depends on the label of the new access and on how many accesses of each class are still outstanding. Addresses play no part in it.

Three saturating-guarded counters hold the outstanding accesses, one per class. A counter goes up when an access of its class is issued and goes down when memory returns a completion for that class. In weak mode, ordinary and synchronizing accesses fence each other, and synchronizing accesses are fully serialized. In release mode, only acquires hold back ordinary accesses. A release waits for the ordinary accesses and for any earlier release. Acquires are serialized among themselves. Ordinary accesses never wait on one another. A stalled request is held at the input with ready low.

Top module: `lbl_order_gate`

## Requirements
- R1: After reset all class counters are zero, so a request of any label is accepted (ready high) in either mode, and `iss_valid` is low while `req_valid` is low.
- R2: An access is issued in the same cycle it is accepted: `iss_valid` equals `req_valid` and `req_ready`, and `iss_label` equals `req_label`. At most one access is issued per cycle.
- R3: Each class counter is 4 bits wide (at most 15 outstanding). A request whose class counter is already at 15 is held with ready low until a completion of that class arrives.
- R4: In weak mode (`mode_rel`=0), an ordinary access (label 2'b00) waits until no acquire and no release is outstanding. Outstanding ordinary accesses do not block it.
- R5: In weak mode, an acquire (2'b01) or release (2'b10) waits until no access of any class is outstanding.
- R6: In release mode (`mode_rel`=1), an ordinary access waits only until no acquire is outstanding. Outstanding releases do not block it.
- R7: In release mode, an acquire waits only until no other acquire is outstanding. Outstanding ordinary accesses and releases do not block it.
- R8: In release mode, a release waits until no ordinary access and no other release is outstanding. Outstanding acquires do not block it.
- R9: A completion (`cpl_valid` with `cpl_label`) decrements the counter of its class at the next clock edge. Stall decisions use the counts held at the start of a cycle, so a request freed by a completion is accepted one cycle after that completion.
- R10: A completion for a class whose counter is zero is ignored, and the counter stays at zero.
- R11: Label 2'b11 is treated exactly as an ordinary access, both for the stall rules and for counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_rel | input | 1 | 0 = weak ordering, 1 = release ordering |
| req_valid | input | 1 | Request present |
| req_label | input | 2 | Request label: 00 ordinary, 01 acquire, 10 release, 11 ordinary |
| req_ready | output | 1 | Request may be accepted this cycle |
| iss_valid | output | 1 | Access sent to memory this cycle |
| iss_label | output | 2 | Label of the issued access |
| cpl_valid | input | 1 | Completion acknowledge from memory |
| cpl_label | input | 2 | Label class of the completed access |

## Verification
On every cycle, the embedded assertions check the following. No counter is stepped past its limit or below zero. A completion moves its counter by exactly one. Every issued access meets the outstanding-count conditions of its mode and label. Only the bench scenarios can show that the gate is not over-conservative: a permitted access must actually go through while other classes are outstanding. The same holds for the one-cycle delay between a completion and the release of a stalled request, and for the treatment of the spare label.

// File: rtl/lbl_order_pkg.sv
// Package: shared label encoding and class indices for the ordering gate.
// Assumes two-bit labels; the spare code maps onto the ordinary class.
package lbl_order_pkg;
    localparam int LBL_W = 2;
    localparam int NCLS  = 3;
    localparam int CLS_W = 2;

    typedef enum logic [LBL_W-1:0] {
        LBL_ORD = 2'b00,
        LBL_ACQ = 2'b01,
        LBL_REL = 2'b10,
        LBL_SPR = 2'b11
    } lbl_e;

    localparam logic [CLS_W-1:0] C_ORD = 2'd0;
    localparam logic [CLS_W-1:0] C_ACQ = 2'd1;
    localparam logic [CLS_W-1:0] C_REL = 2'd2;

    // Map a label onto its counting class (spare code counts as ordinary).
    function automatic logic [CLS_W-1:0] cls_of(input logic [LBL_W-1:0] lbl);
        case (lbl)
            LBL_ACQ: cls_of = C_ACQ;
            LBL_REL: cls_of = C_REL;
            default: cls_of = C_ORD;
        endcase
    endfunction
endpackage

// File: rtl/lbl_cls_counter.sv
// Module: outstanding-access counter for one label class.
// Counts up on issue, down on completion; a completion at zero is dropped.
// Assumes the issuing logic never raises inc while full is high.
module lbl_cls_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             empty,
    output logic             full
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             dec_ok;
    logic [CNT_W-1:0] cnt_nxt;

    assign dec_ok = dec && (cnt != '0);
    assign empty  = (cnt == '0);
    assign full   = (cnt == CNT_MAX);

    // Next count: net effect of one possible issue and one possible completion.
    always_comb begin
        cnt_nxt = cnt;
        if (inc && !dec_ok)
            cnt_nxt = cnt + 1'b1;
        else if (!inc && dec_ok)
            cnt_nxt = cnt - 1'b1;
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (cnt != CNT_MAX));

    p_dec_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && (cnt != '0)) |=> (cnt == $past(cnt) - 1'b1));

    p_zero_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && (cnt == '0)) |=> (cnt == '0));
endmodule

// File: rtl/lbl_issue_rule.sv
// Module: combinational issue permission for the head request.
// Takes the request class, the model select and per-class empty/full flags.
// Assumes the flags reflect counts registered at the start of the cycle.
module lbl_issue_rule
    import lbl_order_pkg::*;
(
    input  logic             mode_rel,
    input  logic [CLS_W-1:0] cls,
    input  logic [NCLS-1:0]  empty,
    input  logic [NCLS-1:0]  full,
    output logic             go
);
    logic order_ok;
    logic room_ok;

    // Ordering condition per model and class.
    always_comb begin
        order_ok = 1'b0;
        if (!mode_rel) begin
            case (cls)
                C_ORD:   order_ok = empty[C_ACQ] && empty[C_REL];
                default: order_ok = &empty;
            endcase
        end else begin
            case (cls)
                C_ORD:   order_ok = empty[C_ACQ];
                C_ACQ:   order_ok = empty[C_ACQ];
                default: order_ok = empty[C_ORD] && empty[C_REL];
            endcase
        end
    end

    // Counter room check for the request's own class.
    always_comb begin
        room_ok = !full[cls];
    end

    assign go = order_ok && room_ok;
endmodule

// File: rtl/lbl_order_gate.sv
// Module: top of the labeled access ordering gate.
// Issues a labeled request to memory in the cycle it is accepted, when the
// selected model and the per-class outstanding counts allow it.
// Assumes memory always takes an issued access and returns one completion
// per issued access, tagged with the same label class.
module lbl_order_gate
    import lbl_order_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_rel,
    input  logic             req_valid,
    input  logic [LBL_W-1:0] req_label,
    output logic             req_ready,
    output logic             iss_valid,
    output logic [LBL_W-1:0] iss_label,
    input  logic             cpl_valid,
    input  logic [LBL_W-1:0] cpl_label
);
    logic [CLS_W-1:0] req_cls;
    logic [CLS_W-1:0] cpl_cls;
    logic [NCLS-1:0]  inc;
    logic [NCLS-1:0]  dec;
    logic [NCLS-1:0]  empty;
    logic [NCLS-1:0]  full;
    logic [CNT_W-1:0] cnt [NCLS];
    logic             go;

    // Class decode of the incoming request and completion.
    always_comb begin
        req_cls = cls_of(req_label);
        cpl_cls = cls_of(cpl_label);
    end

    lbl_issue_rule u_rule (
        .mode_rel (mode_rel),
        .cls      (req_cls),
        .empty    (empty),
        .full     (full),
        .go       (go)
    );

    assign req_ready = go;
    assign iss_valid = req_valid && go;
    assign iss_label = req_label;

    generate
        for (genvar k = 0; k < NCLS; k++) begin : g_cls
            assign inc[k] = iss_valid && (req_cls == CLS_W'(k));
            assign dec[k] = cpl_valid && (cpl_cls == CLS_W'(k));

            lbl_cls_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (inc[k]),
                .dec   (dec[k]),
                .cnt   (cnt[k]),
                .empty (empty[k]),
                .full  (full[k])
            );
        end
    endgenerate

    p_iss_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> req_valid);

    p_one_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc));

    p_weak_ord_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !mode_rel && (req_cls == C_ORD))
            |-> (cnt[C_ACQ] == '0 && cnt[C_REL] == '0));

    p_weak_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !mode_rel && (req_cls != C_ORD))
            |-> (cnt[C_ORD] == '0 && cnt[C_ACQ] == '0 && cnt[C_REL] == '0));

    p_rel_ord_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && mode_rel && (req_cls == C_ORD)) |-> (cnt[C_ACQ] == '0));

    p_rel_acq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && mode_rel && (req_cls == C_ACQ)) |-> (cnt[C_ACQ] == '0));

    p_rel_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && mode_rel && (req_cls == C_REL))
            |-> (cnt[C_ORD] == '0 && cnt[C_REL] == '0));
endmodule

// File: tb/lbl_order_gate_tb_top.sv
`timescale 1ns/1ps
module lbl_order_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_rel = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_label = 2'b00;
    logic       req_ready;
    logic       iss_valid;
    logic [1:0] iss_label;
    logic       cpl_valid = 1'b0;
    logic [1:0] cpl_label = 2'b00;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    lbl_order_gate dut_i (
        .clk(clk), .rst_n(rst_n), .mode_rel(mode_rel),
        .req_valid(req_valid), .req_label(req_label), .req_ready(req_ready),
        .iss_valid(iss_valid), .iss_label(iss_label),
        .cpl_valid(cpl_valid), .cpl_label(cpl_label)
    );

    localparam logic [1:0] ORD = 2'b00, ACQ = 2'b01, REL = 2'b10, SPR = 2'b11;

    // Vector: {mode, n_ord[4], n_acq, n_rel, probe label[2], exp ready, req id[4]}
    localparam int NV = 18;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 4'd0, 1'b0, 1'b0, ORD, 1'b1, 4'd1},  // R1 idle ordinary
        {1'b0, 4'd2, 1'b0, 1'b0, ORD, 1'b1, 4'd4},  // R4 ordinaries do not block
        {1'b0, 4'd0, 1'b1, 1'b0, ORD, 1'b0, 4'd4},  // R4 acquire blocks
        {1'b0, 4'd0, 1'b0, 1'b1, ORD, 1'b0, 4'd4},  // R4 release blocks
        {1'b0, 4'd1, 1'b0, 1'b0, ACQ, 1'b0, 4'd5},  // R5 ordinary blocks acquire
        {1'b0, 4'd1, 1'b0, 1'b0, REL, 1'b0, 4'd5},  // R5 ordinary blocks release
        {1'b0, 4'd0, 1'b1, 1'b0, REL, 1'b0, 4'd5},  // R5 sync serialized
        {1'b0, 4'd0, 1'b0, 1'b1, ACQ, 1'b0, 4'd5},  // R5 sync serialized
        {1'b0, 4'd0, 1'b0, 1'b0, REL, 1'b1, 4'd5},  // R5 idle release
        {1'b1, 4'd0, 1'b0, 1'b1, ORD, 1'b1, 4'd6},  // R6 release does not block
        {1'b1, 4'd0, 1'b1, 1'b0, ORD, 1'b0, 4'd6},  // R6 acquire blocks
        {1'b1, 4'd3, 1'b0, 1'b1, ACQ, 1'b1, 4'd7},  // R7 ord and rel do not block
        {1'b1, 4'd0, 1'b1, 1'b0, ACQ, 1'b0, 4'd7},  // R7 acquires serialized
        {1'b1, 4'd1, 1'b0, 1'b0, REL, 1'b0, 4'd8},  // R8 ordinary blocks release
        {1'b1, 4'd0, 1'b0, 1'b1, REL, 1'b0, 4'd8},  // R8 releases serialized
        {1'b1, 4'd0, 1'b1, 1'b0, REL, 1'b1, 4'd8},  // R8 acquire does not block
        {1'b1, 4'd0, 1'b1, 1'b0, SPR, 1'b0, 4'd11}, // R11 spare acts ordinary
        {1'b1, 4'd0, 1'b0, 1'b1, SPR, 1'b1, 4'd11}  // R11 spare acts ordinary
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [1:0] lbl);
        @(negedge clk);
        req_valid = 1'b1; req_label = lbl;
        #1 chk("R2 preload accept", {3'b0, iss_valid}, 4'd1);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic complete(input logic [1:0] lbl);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_label = lbl;
        @(posedge clk);
        #1 cpl_valid = 1'b0;
    endtask

    // Probe without issuing: drive a request, sample, withdraw before the edge.
    task automatic probe(input string tag, input logic [1:0] lbl, input logic exp);
        @(negedge clk);
        req_valid = 1'b1; req_label = lbl;
        #1;
        chk(tag, {3'b0, req_ready}, {3'b0, exp});
        chk(tag, {3'b0, iss_valid}, {3'b0, exp});
        if (exp) chk({tag, " R2 label"}, {2'b0, iss_label}, {2'b0, lbl});
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [13:0] v;
            v = VEC[i];
            do_reset();
            mode_rel = 1'b1;
            if (v[7]) issue(REL);
            for (int j = 0; j < int'(v[12:9]); j++) issue(ORD);
            if (v[8]) issue(ACQ);
            @(negedge clk);
            mode_rel = v[13];
            probe($sformatf("R%0d vector %0d", v[3:0], i), v[6:5], v[4]);
        end

        // R1: reset state
        do_reset();
        #1 chk("R1 idle no issue", {3'b0, iss_valid}, 4'd0);
        mode_rel = 1'b0;
        probe("R1 weak acq", ACQ, 1'b1);
        mode_rel = 1'b1;
        probe("R1 rel ord", ORD, 1'b1);
        probe("R1 rel rel", REL, 1'b1);

        // R3: counter limit, freed by a completion
        do_reset();
        mode_rel = 1'b1;
        for (int j = 0; j < 15; j++) issue(ORD);
        probe("R3 full blocks", ORD, 1'b0);
        probe("R3 full spare blocks", SPR, 1'b0);
        complete(ORD);
        probe("R3 room after completion", ORD, 1'b1);

        // R9: stalled request held, accepted one cycle after the completion
        do_reset();
        mode_rel = 1'b0;
        issue(ACQ);
        @(negedge clk);
        req_valid = 1'b1; req_label = ORD;
        cpl_valid = 1'b1; cpl_label = ACQ;
        #1 chk("R9 same cycle still stalled", {3'b0, req_ready}, 4'd0);
        @(posedge clk);
        #1 cpl_valid = 1'b0;
        @(negedge clk);
        #1 chk("R9 accepted next cycle", {3'b0, iss_valid}, 4'd1);
        @(posedge clk);
        #1 req_valid = 1'b0;
        probe("R9 ordinary now outstanding", ACQ, 1'b0);

        // R10: completion at zero ignored
        do_reset();
        mode_rel = 1'b1;
        complete(REL);
        complete(ORD);
        probe("R10 rel count still zero", REL, 1'b1);
        for (int j = 0; j < 15; j++) issue(ORD);
        probe("R10 ord count reached exactly 15", ORD, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule